// File: doc/BRIEF.md
# Line-Rate Horizontal Pulse Generator with Half-Line Lockout

This block takes a clock-synchronous, active-low composite sync bit and turns it into two timing strobes. The first is a clean horizontal pulse train with one pulse per video line. Every accepted falling sync edge starts a fixed-width, active-low pulse. Accepting an edge also arms a lockout window of roughly three quarters of a line. Falling edges that arrive inside that window produce no pulse. These include the half-line equalizing and serration pulses of the vertical blanking interval, and any glitch during a pulse.

The second strobe is an active-low back-porch gate. It fires a short, fixed delay after every rising sync edge, whether or not the lockout is active. This includes the rising edges of serration pulses. A downstream clamp can use it to sample the blanking level.

All widths and the lockout are counted in ticks. One tick lasts `rate_div + 1` clock cycles, so a single input value rescales the whole block for a different scan rate. The back-porch start delay is a fixed number of plain clock cycles and does not scale.

Two state machines do the work.

The line machine has three states:
- `LN_ARMED`: waits for a falling edge.
- `LN_PULSE`: drives the horizontal output low.
- `LN_LOCKED`: ignores falling edges.

Its transitions are:
- ARMED→PULSE on a falling edge. This starts both the width timer and the lockout timer.
- PULSE→LOCKED when the width expires and the lockout is still running.
- PULSE→ARMED when the width expires and the lockout has already finished.
- LOCKED→ARMED when the lockout expires.

The porch machine also has three states:
- `BP_IDLE`: waits for a rising edge.
- `BP_WAIT`: counts the start delay.
- `BP_ACTIVE`: drives the porch output low.

Its transitions are:
- IDLE→WAIT on a rising edge. With a zero delay it goes IDLE→ACTIVE directly.
- WAIT→ACTIVE when the delay count ends.
- ACTIVE→IDLE when the porch width expires.

Top module: `hsync_line_gen`

## Requirements
- R1: While `rst_n` is low and on release of reset, `hout_n` and `bporch_n` are both high (inactive).
- R2: When the line machine is armed, a high-to-low change of `csync_n` is sampled at clock edge P0. `hout_n` is then low in the cycle that follows P0, a delay of one register stage.
- R3: Each horizontal pulse keeps `hout_n` low for exactly H_TICKS × (rate_div+1) consecutive cycles.
- R4: Let L = lock_ticks × (rate_div+1) and let the accepted falling edge be sampled at edge 0. A later falling edge sampled at edge k is ignored when k ≤ L and accepted when k > L.
- R5: Neither one-shot retriggers. A falling edge during a horizontal pulse does not lengthen it. A rising edge during the porch delay or the porch pulse does not restart it.
- R6: A rising edge of `csync_n` sampled at edge P0 in the idle porch state makes `bporch_n` low from the cycle after edge P0+BP_DELAY. It stays low for exactly BP_TICKS × (rate_div+1) cycles.
- R7: The porch gate fires on every rising sync edge, including those of equalizing and serration pulses. The lockout does not affect it.
- R8: `rate_div` scales the horizontal width, the lockout and the porch width. It does not scale the porch start delay.
- R9: A sync stream of normal lines, equalizing half-lines, serration half-lines, equalizing half-lines and normal lines gives exactly one horizontal pulse per line period, aligned to the line-start edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Clock-synchronous composite sync, active low |
| rate_div | input | RATE_W | Clock cycles per tick, minus one |
| lock_ticks | input | CNT_W | Lockout length in ticks, counted from the accepted edge |
| hout_n | output | 1 | Horizontal pulse, active low |
| bporch_n | output | 1 | Back-porch gate, active low |

## Verification
A wrong line state shows up at the ports within one line period. A machine that is stuck in lockout drops the next line pulse. A machine that is armed too early emits an extra pulse 32 cycles after a line start, in the middle of the equalizing or serration run. Timer faults change the measured width of `hout_n` or `bporch_n` on the very pulse they occur in. A porch machine that retriggers or skips its delay shifts the first low sample of `bporch_n` relative to the rising edge within the same half-line. For these reasons the stream test records, for every segment, the index of the first low sample and the count of low samples of each output.

// File: rtl/hsync_pkg.sv
package hsync_pkg;

    typedef enum logic [1:0] {
        LN_ARMED  = 2'd0,
        LN_PULSE  = 2'd1,
        LN_LOCKED = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        BP_IDLE   = 2'd0,
        BP_WAIT   = 2'd1,
        BP_ACTIVE = 2'd2
    } porch_state_e;

endpackage

// File: rtl/hs_edge_detect.sv
module hs_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall_evt,
    output logic rise_evt
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= din;
    end

    assign fall_evt = prev_q & ~din;
    assign rise_evt = ~prev_q & din;
endmodule

// File: rtl/hs_span_timer.sv
module hs_span_timer #(
    parameter int RATE_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  ticks,
    input  logic [RATE_W-1:0] rate,
    output logic              busy,
    output logic              last
);
    logic [RATE_W-1:0] pre_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pre_q  <= '0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            pre_q  <= '0;
            cnt_q  <= (ticks == '0) ? '0 : CNT_W'(ticks - 1'b1);
        end else if (busy_q) begin
            if (pre_q == rate) begin
                pre_q <= '0;
                if (cnt_q == '0) busy_q <= 1'b0;
                else             cnt_q  <= CNT_W'(cnt_q - 1'b1);
            end else begin
                pre_q <= RATE_W'(pre_q + 1'b1);
            end
        end
    end

    assign busy = busy_q;
    assign last = busy_q && (pre_q == rate) && (cnt_q == '0);

    assert_timer_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(start));
endmodule

// File: rtl/hs_line_fsm.sv
module hs_line_fsm
    import hsync_pkg::*;
#(
    parameter int RATE_W  = 8,
    parameter int CNT_W   = 8,
    parameter int H_TICKS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_evt,
    input  logic [RATE_W-1:0] rate_div,
    input  logic [CNT_W-1:0]  lock_ticks,
    output logic              hout_n
);
    localparam logic [CNT_W-1:0] H_CNT = CNT_W'(H_TICKS);

    line_state_e state_q, state_d;
    logic start_spans;
    logic width_busy, width_last;
    logic lock_busy, lock_last;

    hs_span_timer #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_width (
        .clk(clk), .rst_n(rst_n), .start(start_spans), .ticks(H_CNT),
        .rate(rate_div), .busy(width_busy), .last(width_last)
    );

    hs_span_timer #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .start(start_spans), .ticks(lock_ticks),
        .rate(rate_div), .busy(lock_busy), .last(lock_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        start_spans = 1'b0;
        unique case (state_q)
            LN_ARMED: begin
                if (fall_evt) begin
                    state_d     = LN_PULSE;
                    start_spans = 1'b1;
                end
            end
            LN_PULSE: begin
                if (width_last)
                    state_d = (lock_busy && !lock_last) ? LN_LOCKED : LN_ARMED;
            end
            LN_LOCKED: begin
                if (lock_last) state_d = LN_ARMED;
            end
            default: state_d = LN_ARMED;
        endcase
    end

    always_comb begin
        hout_n = (state_q != LN_PULSE);
    end

    assert_lead_trigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hout_n) |-> $past(fall_evt));
    assert_width_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hout_n) |-> $past(width_last));
    assert_width_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_PULSE) |-> width_busy);
    assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_LOCKED && fall_evt && !lock_last) |=> hout_n);
    assert_no_retrigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_PULSE && !width_last) |=> (state_q == LN_PULSE));
endmodule

// File: rtl/hs_porch_fsm.sv
module hs_porch_fsm
    import hsync_pkg::*;
#(
    parameter int RATE_W   = 8,
    parameter int CNT_W    = 8,
    parameter int BP_TICKS = 4,
    parameter int BP_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_evt,
    input  logic [RATE_W-1:0] rate_div,
    output logic              bporch_n
);
    localparam int DLY_W = (BP_DELAY > 1) ? $clog2(BP_DELAY) : 1;
    localparam logic [CNT_W-1:0] BP_CNT  = CNT_W'(BP_TICKS);
    localparam logic [DLY_W-1:0] DLY_END = DLY_W'((BP_DELAY > 0) ? BP_DELAY - 1 : 0);

    porch_state_e state_q, state_d;
    logic [DLY_W-1:0] dly_q;
    logic start_gate, gate_busy, gate_last;

    hs_span_timer #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .start(start_gate), .ticks(BP_CNT),
        .rate(rate_div), .busy(gate_busy), .last(gate_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BP_IDLE;
            dly_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == BP_WAIT) dly_q <= DLY_W'(dly_q + 1'b1);
            else                    dly_q <= '0;
        end
    end

    always_comb begin
        state_d    = state_q;
        start_gate = 1'b0;
        unique case (state_q)
            BP_IDLE: begin
                if (rise_evt) begin
                    if (BP_DELAY == 0) begin
                        state_d    = BP_ACTIVE;
                        start_gate = 1'b1;
                    end else begin
                        state_d = BP_WAIT;
                    end
                end
            end
            BP_WAIT: begin
                if (dly_q == DLY_END) begin
                    state_d    = BP_ACTIVE;
                    start_gate = 1'b1;
                end
            end
            BP_ACTIVE: begin
                if (gate_last) state_d = BP_IDLE;
            end
            default: state_d = BP_IDLE;
        endcase
    end

    always_comb begin
        bporch_n = (state_q != BP_ACTIVE);
    end

    assert_porch_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bporch_n) |-> ($past(state_q) == BP_WAIT || $past(rise_evt)));
    assert_porch_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BP_ACTIVE) |-> gate_busy);
    assert_porch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BP_ACTIVE && !gate_last) |=> !bporch_n);
endmodule

// File: rtl/hsync_line_gen.sv
module hsync_line_gen #(
    parameter int RATE_W   = 8,
    parameter int CNT_W    = 8,
    parameter int H_TICKS  = 5,
    parameter int BP_TICKS = 4,
    parameter int BP_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csync_n,
    input  logic [RATE_W-1:0] rate_div,
    input  logic [CNT_W-1:0]  lock_ticks,
    output logic              hout_n,
    output logic              bporch_n
);
    logic fall_evt, rise_evt;

    hs_edge_detect u_edge (
        .clk(clk), .rst_n(rst_n), .din(csync_n),
        .fall_evt(fall_evt), .rise_evt(rise_evt)
    );

    hs_line_fsm #(.RATE_W(RATE_W), .CNT_W(CNT_W), .H_TICKS(H_TICKS)) u_line (
        .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt),
        .rate_div(rate_div), .lock_ticks(lock_ticks), .hout_n(hout_n)
    );

    hs_porch_fsm #(.RATE_W(RATE_W), .CNT_W(CNT_W), .BP_TICKS(BP_TICKS),
                   .BP_DELAY(BP_DELAY)) u_porch (
        .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt),
        .rate_div(rate_div), .bporch_n(bporch_n)
    );

    assert_edges_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_evt, rise_evt}));
endmodule

// File: tb/hsync_line_gen_bench.sv
module hsync_line_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HT = 5;
    localparam int BT = 4;
    localparam int BD = 2;
    localparam int NSEG = 24;
    // each entry: {low cycles, high cycles, expect horizontal pulse}
    localparam logic [23:0] SEG_TABLE [NSEG] = '{
        {8'd5, 8'd59, 8'd1}, {8'd5, 8'd59, 8'd1}, {8'd5, 8'd59, 8'd1},
        {8'd2, 8'd30, 8'd1}, {8'd2, 8'd30, 8'd0}, {8'd2, 8'd30, 8'd1},
        {8'd2, 8'd30, 8'd0}, {8'd2, 8'd30, 8'd1}, {8'd2, 8'd30, 8'd0},
        {8'd26, 8'd6, 8'd1}, {8'd26, 8'd6, 8'd0}, {8'd26, 8'd6, 8'd1},
        {8'd26, 8'd6, 8'd0}, {8'd26, 8'd6, 8'd1}, {8'd26, 8'd6, 8'd0},
        {8'd2, 8'd30, 8'd1}, {8'd2, 8'd30, 8'd0}, {8'd2, 8'd30, 8'd1},
        {8'd2, 8'd30, 8'd0}, {8'd2, 8'd30, 8'd1}, {8'd2, 8'd30, 8'd0},
        {8'd5, 8'd59, 8'd1}, {8'd5, 8'd59, 8'd1}, {8'd5, 8'd59, 8'd1}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic csync_n;
    logic [7:0] rate_div;
    logic [7:0] lock_ticks;
    logic hout_n, bporch_n;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsync_line_gen u_hsync_line_gen (
        .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .rate_div(rate_div),
        .lock_ticks(lock_ticks), .hout_n(hout_n), .bporch_n(bporch_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_seg(input int low, input int high,
                           output int hf, output int hc, output int bf, output int bc);
        hf = -1; hc = 0; bf = -1; bc = 0;
        for (int i = 0; i < low + high; i++) begin
            csync_n = (i < low) ? 1'b0 : 1'b1;
            @(posedge clk);
            @(negedge clk);
            if (!hout_n) begin
                if (hf < 0) hf = i;
                hc++;
            end
            if (!bporch_n) begin
                if (bf < 0) bf = i;
                bc++;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hf, hc, bf, bc, sh, sb;
        rst_n = 1'b0; csync_n = 1'b1; rate_div = 8'd0; lock_ticks = 8'd48;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(hout_n == 1'b1, "R1 hout in reset", hout_n, 1);
        check(bporch_n == 1'b1, "R1 porch in reset", bporch_n, 1);
        rst_n = 1'b1;
        run_seg(0, 10, hf, hc, bf, bc);
        check(hc == 0 && bc == 0, "R1 idle after reset", hc + bc, 0);

        // vertical interval stream: R9, R2, R3, R6, R7
        for (int s = 0; s < NSEG; s++) begin
            int lo, hi, eh;
            lo = int'(SEG_TABLE[s][23:16]);
            hi = int'(SEG_TABLE[s][15:8]);
            eh = int'(SEG_TABLE[s][7:0]);
            run_seg(lo, hi, hf, hc, bf, bc);
            check(hf == (eh ? 0 : -1), "R9 R2 pulse start per segment", hf, eh ? 0 : -1);
            check(hc == (eh ? HT : 0), "R9 R3 pulse width per segment", hc, eh ? HT : 0);
            check(bf == lo + BD, "R7 R6 porch start", bf, lo + BD);
            check(bc == BT, "R7 R6 porch width", bc, BT);
        end

        // R4 lockout boundary: edge sampled exactly at L is ignored
        run_seg(0, 100, hf, hc, bf, bc);
        run_seg(5, 43, hf, hc, bf, bc);
        check(hc == HT, "R4 first line accepted", hc, HT);
        run_seg(5, 59, hf, hc, bf, bc);
        check(hc == 0, "R4 edge at lockout end ignored", hc, 0);
        // edge sampled at L+1 is accepted
        run_seg(0, 100, hf, hc, bf, bc);
        run_seg(5, 44, hf, hc, bf, bc);
        run_seg(5, 59, hf, hc, bf, bc);
        check(hf == 0, "R4 edge after lockout accepted", hf, 0);
        check(hc == HT, "R4 accepted pulse width", hc, HT);

        // R5 no retrigger of either one-shot
        run_seg(0, 100, hf, hc, bf, bc);
        run_seg(1, 1, hf, hc, bf, bc);
        sh = hc; sb = bc;
        run_seg(1, 61, hf, hc, bf, bc);
        check(sh + hc == HT, "R5 hout not lengthened", sh + hc, HT);
        check(sb + bc == BT, "R5 porch not restarted", sb + bc, BT);

        // R8 scan-rate scaling with rate_div = 1
        run_seg(0, 100, hf, hc, bf, bc);
        rate_div = 8'd1; lock_ticks = 8'd24;
        run_seg(0, 20, hf, hc, bf, bc);
        run_seg(5, 59, hf, hc, bf, bc);
        check(hc == 2 * HT, "R8 R3 scaled width", hc, 2 * HT);
        check(bf == 5 + BD, "R8 porch delay unscaled", bf, 5 + BD);
        check(bc == 2 * BT, "R8 R6 scaled porch width", bc, 2 * BT);
        run_seg(2, 30, hf, hc, bf, bc);
        check(hf == 0, "R8 R4 scaled lockout ends within line", hf, 0);
        run_seg(2, 30, hf, hc, bf, bc);
        check(hc == 0, "R8 R4 half-line rejected at scaled rate", hc, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule